// File: doc/BRIEF.md
# LCD Panel Timing Generator with Shadowed Configuration

This block produces the raster timing for a parallel RGB panel: a horizontal sync, a vertical sync, a data-enable window and a pixel-clock enable. Software writes every timing value as "count minus one" through a small register port. The values land in a working copy. The counters never see the working copy directly. They run from a shadow copy, which is refreshed only at the start of a frame, and only when the protect bit is clear. A whole new mode can therefore be written across many register accesses and still switch in one step, at the vsync edge.

The timing order inside each line is: sync pulse, back porch, active region, front porch. Frames follow the same order, counted in lines. The pixel-clock enable either fires on every source clock or once every N+1 source clocks. Output runs only when both an immediate enable and a deferred enable are set. A frame interrupt can flag each vsync start. The flag is cleared by writing one to its bit.

Top module: `lcd_tgen`

## Requirements
- R1: After reset, hsync, vsync, de, pix_ce and irq are low, and every register reads back zero.
- R2: Timing runs only while the immediate enable (CTRL bit 0) and the shadowed deferred enable (CTRL bit 1) are both set. Clearing the immediate enable drives hsync, vsync and de low in the cycle after the write.
- R3: A line lasts (hsw+1)+(hbp+1)+(hact+1)+(hfp+1) pixel periods. hsync is high for the first hsw+1 of them. Fields: HTIM[7:0]=hsw, HTIM[15:8]=hbp, HTIM[23:16]=hfp, SIZE[10:0]=hact.
- R4: A frame lasts (vsw+1)+(vbp+1)+(vact+1)+(vfp+1) lines. vsync is high for the first vsw+1 lines. Fields: VTIM[7:0]=vsw, VTIM[15:8]=vbp, VTIM[23:16]=vfp, SIZE[26:16]=vact.
- R5: de is high only where the horizontal and the vertical counters are both in their active regions. This gives hact+1 pixels per active line, followed by the front porch before the next hsync.
- R6: With CTRL bit 2 (divider select) set and CTRL[15:8]=N nonzero, pix_ce pulses once every N+1 source cycles, and the counters advance only on pix_ce. With the select clear, or with N=0, pix_ce is high on every cycle while running.
- R7: While running, a write to any timing field, to the divider fields or to the deferred enable takes effect only at the next frame start, that is, the cycle in which vsync rises.
- R8: While LOCK bit 0 (protect) is set, the shadow copy does not change. The first frame start after protect is cleared loads the working copy.
- R9: While timing is stopped and protect is clear, the shadow copy follows the working copy on every cycle. A restart therefore uses the latest values from its first pixel.
- R10: With IRQ bit 0 (enable) set, IRQ bit 1 (pending) is set at each frame start, and irq equals pending. Writing one to IRQ bit 1 clears pending. A frame start in the same cycle wins over the clear.
- R11: Registers read back their working values at the write positions. The addresses are CTRL=0, VTIM=1, HTIM=2, SIZE=3, IRQ=4, LOCK=5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable, active high |
| irq | output | 1 | Frame interrupt |

## Verification
The hardest case to reach is a register write that lands mid-frame while the counters are running. The bench must show that the old timing persists until the next vsync edge, and not merely that the new timing appears eventually. To get there, the stimulus first synchronises to a vsync rise and then writes. It measures one hsync period inside the same frame, then resynchronises to the following vsync rise and measures again. The protect case uses the same sequence, run over two frames with the lock held, before the lock is released. A stop, rewrite and restart sequence covers the shadow tracking while idle.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;
  localparam int PW  = 8;        // porch / sync field width
  localparam int AW  = 11;       // active size field width
  localparam int DW  = 8;        // divider field width
  localparam int CW  = AW + 2;   // counter width, covers 3*2^PW + 2^AW
  localparam int RDW = 32;       // register data width
  localparam int RAW = 3;        // register address width

  localparam logic [RAW-1:0] A_CTRL = 3'd0;
  localparam logic [RAW-1:0] A_VTIM = 3'd1;
  localparam logic [RAW-1:0] A_HTIM = 3'd2;
  localparam logic [RAW-1:0] A_SIZE = 3'd3;
  localparam logic [RAW-1:0] A_IRQ  = 3'd4;
  localparam logic [RAW-1:0] A_LOCK = 3'd5;

  typedef struct packed {
    logic [PW-1:0] hsw;
    logic [PW-1:0] hbp;
    logic [PW-1:0] hfp;
    logic [AW-1:0] hact;
    logic [PW-1:0] vsw;
    logic [PW-1:0] vbp;
    logic [PW-1:0] vfp;
    logic [AW-1:0] vact;
    logic [DW-1:0] div;
    logic          div_sel;
    logic          run_def;
  } tcfg_t;

  // every field is stored minus one, so four spans add four
  function automatic logic [CW-1:0] span_total(input logic [PW-1:0] sw,
      input logic [PW-1:0] bp, input logic [PW-1:0] fp, input logic [AW-1:0] act);
    return CW'(sw) + CW'(bp) + CW'(fp) + CW'(act) + CW'(4);
  endfunction

  function automatic logic in_sync(input logic [CW-1:0] cnt, input logic [PW-1:0] sw);
    return cnt <= CW'(sw);
  endfunction

  function automatic logic in_window(input logic [CW-1:0] cnt, input logic [PW-1:0] sw,
      input logic [PW-1:0] bp, input logic [AW-1:0] act);
    logic [CW-1:0] lo;
    lo = CW'(sw) + CW'(bp) + CW'(2);
    return (cnt >= lo) && (cnt < lo + CW'(act) + CW'(1));
  endfunction
endpackage

// File: rtl/lcd_tgen_regs.sv
module lcd_tgen_regs
  import lcd_tgen_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [RAW-1:0] addr,
  input  logic [RDW-1:0] wdata,
  output logic [RDW-1:0] rdata,
  input  logic           frame_tick,
  input  logic           pend_set,
  output logic           run_now,
  output tcfg_t          shad,
  output logic           irq
);
  tcfg_t work_q, shad_q;
  logic  run_now_q, protect_q, irq_en_q, pend_q;
  logic  clr_req;
  logic  unused_wd;

  assign unused_wd = ^wdata;
  assign clr_req   = wr && (addr == A_IRQ) && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q    <= '0;
      run_now_q <= 1'b0;
      protect_q <= 1'b0;
      irq_en_q  <= 1'b0;
    end else if (wr) begin
      case (addr)
        A_CTRL: begin
          run_now_q      <= wdata[0];
          work_q.run_def <= wdata[1];
          work_q.div_sel <= wdata[2];
          work_q.div     <= wdata[8 +: DW];
        end
        A_VTIM: begin
          work_q.vsw <= wdata[0 +: PW];
          work_q.vbp <= wdata[8 +: PW];
          work_q.vfp <= wdata[16 +: PW];
        end
        A_HTIM: begin
          work_q.hsw <= wdata[0 +: PW];
          work_q.hbp <= wdata[8 +: PW];
          work_q.hfp <= wdata[16 +: PW];
        end
        A_SIZE: begin
          work_q.hact <= wdata[0 +: AW];
          work_q.vact <= wdata[16 +: AW];
        end
        A_IRQ:  irq_en_q  <= wdata[0];
        A_LOCK: protect_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       shad_q <= '0;
    else if (frame_tick && !protect_q) shad_q <= work_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     pend_q <= 1'b0;
    else if (pend_set && irq_en_q)  pend_q <= 1'b1;
    else if (clr_req)               pend_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[0]       = run_now_q;
        rdata[1]       = work_q.run_def;
        rdata[2]       = work_q.div_sel;
        rdata[8 +: DW] = work_q.div;
      end
      A_VTIM: begin
        rdata[0 +: PW]  = work_q.vsw;
        rdata[8 +: PW]  = work_q.vbp;
        rdata[16 +: PW] = work_q.vfp;
      end
      A_HTIM: begin
        rdata[0 +: PW]  = work_q.hsw;
        rdata[8 +: PW]  = work_q.hbp;
        rdata[16 +: PW] = work_q.hfp;
      end
      A_SIZE: begin
        rdata[0 +: AW]  = work_q.hact;
        rdata[16 +: AW] = work_q.vact;
      end
      A_IRQ: begin
        rdata[0] = irq_en_q;
        rdata[1] = pend_q;
      end
      A_LOCK: rdata[0] = protect_q;
      default: ;
    endcase
  end

  assign run_now = run_now_q;
  assign shad    = shad_q;
  assign irq     = pend_q;

  AST_SHADOW_ONLY_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(shad_q)); // R7
  AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    protect_q |=> $stable(shad_q)); // R8
  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !pend_set) |=> !irq); // R10
endmodule

// File: rtl/lcd_tgen_pixdiv.sv
module lcd_tgen_pixdiv
  import lcd_tgen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic          div_sel,
  input  logic [DW-1:0] div,
  output logic          ce
);
  logic [DW-1:0] cnt_q;
  logic          bypass;

  assign bypass = !div_sel || (div == '0);
  assign ce     = running && (bypass || (cnt_q == div));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!running || bypass) cnt_q <= '0;
    else if (cnt_q == div)     cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  AST_CE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !bypass) |=> (!ce || bypass)); // R6
endmodule

// File: rtl/lcd_tgen_counters.sv
module lcd_tgen_counters
  import lcd_tgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  running,
  input  logic  ce,
  input  tcfg_t cfg,
  output logic  hsync,
  output logic  vsync,
  output logic  de,
  output logic  wrap
);
  logic [CW-1:0] hcnt_q, vcnt_q, htot, vtot;
  logic          h_last, v_last;
  logic          unused_cfg;

  assign unused_cfg = ^{cfg.div, cfg.div_sel, cfg.run_def};
  assign htot   = span_total(cfg.hsw, cfg.hbp, cfg.hfp, cfg.hact);
  assign vtot   = span_total(cfg.vsw, cfg.vbp, cfg.vfp, cfg.vact);
  assign h_last = hcnt_q == htot - CW'(1);
  assign v_last = vcnt_q == vtot - CW'(1);
  assign wrap   = running && ce && h_last && v_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !running) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (ce) begin
      if (h_last) begin
        hcnt_q <= '0;
        vcnt_q <= v_last ? '0 : vcnt_q + CW'(1);
      end else begin
        hcnt_q <= hcnt_q + CW'(1);
      end
    end
  end

  assign hsync = running && in_sync(hcnt_q, cfg.hsw);
  assign vsync = running && in_sync(vcnt_q, cfg.vsw);
  assign de    = running && in_window(hcnt_q, cfg.hsw, cfg.hbp, cfg.hact)
                         && in_window(vcnt_q, cfg.vsw, cfg.vbp, cfg.vact);

  AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync)); // R5
  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (hcnt_q < htot)); // R3
  AST_VCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (vcnt_q < vtot)); // R4
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
  import lcd_tgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        pix_ce,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic        irq
);
  tcfg_t shad;
  logic  run_now, running, ce, wrap, frame_tick;

  assign running    = run_now && shad.run_def;
  assign frame_tick = wrap || !running;
  assign pix_ce     = ce;

  lcd_tgen_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .frame_tick(frame_tick), .pend_set(wrap),
    .run_now(run_now), .shad(shad), .irq(irq)
  );

  lcd_tgen_pixdiv u_div (
    .clk(clk), .rst_n(rst_n), .running(running), .div_sel(shad.div_sel),
    .div(shad.div), .ce(ce)
  );

  lcd_tgen_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .running(running), .ce(ce), .cfg(shad),
    .hsync(hsync), .vsync(vsync), .de(de), .wrap(wrap)
  );

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_now) |-> (!hsync && !vsync && !de && !pix_ce)); // R2
endmodule

// File: tb/lcd_tgen_test.sv
module lcd_tgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_ce, hsync, vsync, de, irq;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  lcd_tgen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_ce(pix_ce),
    .hsync(hsync), .vsync(vsync), .de(de), .irq(irq)
  );

  // expected line/frame length from the requirement formula
  function automatic int span(input int sw, input int bp, input int act, input int fp);
    return (sw + 1) + (bp + 1) + (act + 1) + (fp + 1);
  endfunction

  function automatic logic sig(input int which);
    case (which)
      0: return hsync;
      1: return vsync;
      2: return de;
      default: return irq;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_edge(input int which, input bit rise, output int at);
    logic prev;
    prev = sig(which);
    forever begin
      @(negedge clk);
      if (rise ? (sig(which) && !prev) : (!sig(which) && prev)) break;
      prev = sig(which);
    end
    at = $time / 4;
  endtask

  task automatic hperiod(output int p);
    int t0, t1;
    wait_edge(0, 1'b1, t0);
    wait_edge(0, 1'b1, t1);
    p = t1 - t0;
  endtask

  task automatic count_ce(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pix_ce) c++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 hsync", hsync, 0); chk("R1 vsync", vsync, 0);
    chk("R1 de", de, 0); chk("R1 irq", irq, 0); chk("R1 pix_ce", pix_ce, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 readback", int'(d), 0);
    end
  endtask

  task automatic t_enables;
    int hs, tmp;
    logic [31:0] d;
    wr(3'd1, 32'h0000_0000);            // vsw=vbp=vfp=0
    wr(3'd2, 32'h0001_0101);            // hsw=hbp=hfp=1
    wr(3'd3, 32'h0002_0003);            // hact=3, vact=2
    rd(3'd3, d); chk("R11 SIZE readback", int'(d), 32'h0002_0003);
    rd(3'd2, d); chk("R11 HTIM readback", int'(d), 32'h0001_0101);
    wr(3'd0, 32'h1);                    // immediate only
    hs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (hsync || de || vsync) hs++; end
    chk("R2 immediate only idle", hs, 0);
    wr(3'd0, 32'h2);                    // deferred only
    hs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (hsync || de || vsync || pix_ce) hs++; end
    chk("R2 deferred only idle", hs, 0);
    wr(3'd0, 32'h3);
    hperiod(tmp);
    chk("R2 both enables run", tmp, span(1, 1, 3, 1));
  endtask

  task automatic t_horiz;
    int p, t0, t1;
    hperiod(p);            chk("R3 line length", p, span(1, 1, 3, 1));
    wait_edge(0, 1'b1, t0); wait_edge(0, 1'b0, t1);
    chk("R3 hsync width", t1 - t0, 2);
    wait_edge(2, 1'b1, t0); wait_edge(2, 1'b0, t1);
    chk("R5 de width", t1 - t0, 4);
    wait_edge(2, 1'b1, t0); wait_edge(0, 1'b1, t1);
    chk("R5 de to next hsync", t1 - t0, 4 + 2);
  endtask

  task automatic t_vert;
    int t0, t1, de_n, hs_n, n;
    logic ph, pv;
    wait_edge(1, 1'b1, t0); wait_edge(1, 1'b0, t1);
    chk("R4 vsync width", t1 - t0, 10);
    wait_edge(1, 1'b1, t0);
    de_n = 0; hs_n = 0; n = 0; ph = hsync; pv = vsync;
    forever begin
      @(negedge clk); n++;
      if (de) de_n++;
      if (hsync && !ph) hs_n++;
      if (vsync && !pv) break;
      ph = hsync; pv = vsync;
    end
    chk("R4 frame cycles", n, span(0, 0, 2, 0) * span(1, 1, 3, 1));
    chk("R4 lines per frame", hs_n, span(0, 0, 2, 0));
    chk("R5 de per frame", de_n, 12);
  endtask

  task automatic t_div_deferred;
    int c, p, t;
    count_ce(20, c); chk("R6 bypass every cycle", c, 20);
    wr(3'd0, 32'h0000_0503);            // N=5 but select clear
    wait_edge(1, 1'b1, t);
    count_ce(20, c); chk("R6 select clear still every cycle", c, 20);
    wait_edge(1, 1'b1, t);
    wr(3'd0, 32'h0000_0207);            // divide by 3, mid-frame
    hperiod(p); chk("R7 old line length before vsync", p, 10);
    wait_edge(1, 1'b1, t);
    hperiod(p); chk("R7 R6 line length after vsync", p, 30);
    count_ce(30, c); chk("R6 one enable per three cycles", c, 10);
  endtask

  task automatic t_protect;
    int p, t;
    wr(3'd5, 32'h1);
    wr(3'd0, 32'h3);                    // back to 1:1, held by protect
    wait_edge(1, 1'b1, t); wait_edge(1, 1'b1, t);
    hperiod(p); chk("R8 protect holds shadow", p, 30);
    wr(3'd5, 32'h0);
    wait_edge(1, 1'b1, t);
    hperiod(p); chk("R8 load after unprotect", p, 10);
  endtask

  task automatic t_stop_track;
    int p, t;
    wr(3'd0, 32'h2);                    // stop
    chk("R2 stop hsync", hsync, 0); chk("R2 stop vsync", vsync, 0); chk("R2 stop de", de, 0);
    wr(3'd2, 32'h0003_0101);            // hfp=3 while stopped
    wr(3'd0, 32'h3);
    hperiod(p); chk("R9 restart uses new line length", p, 12);
    wr(3'd5, 32'h1);
    wr(3'd0, 32'h2);
    wr(3'd2, 32'h0001_0101);            // change held back by protect
    wr(3'd0, 32'h3);
    hperiod(p); chk("R8 protect while stopped", p, 12);
    wr(3'd5, 32'h0);
    wait_edge(1, 1'b1, t);
    hperiod(p); chk("R8 R9 released at vsync", p, 10);
  endtask

  task automatic t_irq;
    int t, hits;
    logic [31:0] d;
    wr(3'd4, 32'h1);
    wait_edge(1, 1'b1, t);
    chk("R10 irq at frame start", irq, 1);
    rd(3'd4, d); chk("R10 pending readback", int'(d), 3);
    wr(3'd4, 32'h3);
    chk("R10 w1c clears irq", irq, 0);
    wr(3'd4, 32'h0);
    hits = 0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (irq) hits++; end
    chk("R10 disabled stays low", hits, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_horiz();
    t_vert();
    t_div_deferred();
    t_protect();
    t_stop_track();
    t_irq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule